// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces memory addresses for a signal-processing core, so the arithmetic datapath never spends cycles working out where samples live. It holds several independent pointer channels. Each channel has a base address, a buffer length, a signed step and a current index. Several filter stages, such as a chain of biquad sections, can therefore each keep a private circular buffer.

A request names a channel. The block returns that channel's current address one cycle later and moves the channel's pointer. In modulo mode the pointer moves by the step and wraps inside the buffer. In bit-reversed mode a sequential counter is emitted with its bits mirrored, which gives the reordering an FFT needs. Channels are set up through a plain register-write port.

A system normally instantiates one generator per memory, one for program memory and one for data memory, so that both memories are addressed in the same cycle. Requests and addresses travel as valid/ready streams. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. An address waits in its register while `addr_ready` is low, and no new request is taken during that time.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, `addr_valid` is 0 and `req_ready` is 1. Every channel has base 0, length 1, step 0, index 0 and modulo mode.
- R2: When a request is taken on a clock edge, `addr_valid` is 1 after that edge. `addr` then equals the selected channel's base plus its offset as they stood before the edge.
- R3: In modulo mode (`cfg_mode` = 0), each taken request sets the index to (index + step) mod length. The step is a signed two's-complement value with |step| <= length. This includes step = length and step = -length, which both leave the index unchanged.
- R4: In bit-reversed mode (`cfg_mode` = 1), the length must be 2^k. The offset is the k-bit reversal of the index, where bit 0 of the index becomes bit k-1 of the offset. Each taken request adds 1 to the index, wrapping at 2^k, and the step is ignored.
- R5: The address is (base + offset) modulo 2^16.
- R6: A configuration write loads base, length, step and mode into channel `cfg_ch` and sets its index to 0 on the same edge. If a request to the same channel is taken on that edge, it returns the address from the pre-write state, and its advance is discarded.
- R7: A taken request changes only the selected channel's index. All other channels keep their state.
- R8: While `addr_ready` stays 1, `req_ready` stays 1, and a request may be taken on every cycle, including back-to-back requests to different channels.
- R9: While `addr_valid` is 1 and `addr_ready` is 0, `req_ready` is 0. `addr` and `addr_valid` hold their values, and no channel index advances.
- R10: A channel of length 1 returns its base address on every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel written by `cfg_we` |
| cfg_base | input | 16 | Buffer base address |
| cfg_len | input | 11 | Buffer length, 1 to 1024 |
| cfg_step | input | 11 | Signed step for modulo mode |
| cfg_mode | input | 1 | 0 = modulo, 1 = bit-reversed |
| req_valid | input | 1 | Address request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_ch | input | 2 | Channel requested |
| addr_valid | output | 1 | `addr` holds a generated address |
| addr_ready | input | 1 | Consumer takes `addr` this cycle |
| addr | output | 16 | Generated address |

## Verification
Two functions can fall in the same cycle: a configuration write to a channel and a taken request to that same channel. Directed steps place both on one edge for both modes. Random traffic also lets channel numbers collide by chance while the output is sometimes stalled. The bench judges each case by checking that the returned address comes from the pre-write state, and that the next request sees index zero under the new settings.

// File: rtl/cag_pkg.sv
package cag_pkg;

  typedef enum logic {
    MODE_MOD  = 1'b0,
    MODE_BREV = 1'b1
  } mode_e;

  // Position of the highest set bit; used to derive k from a power-of-two length.
  function automatic int unsigned cag_log2(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/cag_bitrev.sv
module cag_bitrev #(
  parameter int IW = 10,
  parameter int KW = $clog2(IW + 1)
) (
  input  logic [IW-1:0] val,
  input  logic [KW-1:0] k,
  output logic [IW-1:0] rev
);
  logic [IW-1:0] mirrored;

  generate
    for (genvar i = 0; i < IW; i++) begin : g_mirror
      assign mirrored[i] = val[IW-1-i];
    end
  endgenerate

  // Mirror all IW bits, then drop the low bits that belong above k.
  assign rev = mirrored >> (KW'(IW) - k);
endmodule

// File: rtl/cag_wrap.sv
module cag_wrap #(
  parameter int IW = 10,
  parameter int LW = IW + 1
) (
  input  logic [IW-1:0] idx,
  input  logic [LW-1:0] len,
  input  logic [LW-1:0] step,
  input  logic          brev,
  output logic [IW-1:0] nxt
);
  logic signed [IW+1:0] sum;
  logic signed [IW+1:0] lenx;
  logic signed [IW+1:0] fixed;
  logic        [LW-1:0] inc;

  always_comb begin
    sum  = $signed({2'b00, idx}) + $signed({step[LW-1], step});
    lenx = $signed({1'b0, len});
    if (sum < 0)          fixed = sum + lenx;
    else if (sum >= lenx) fixed = sum - lenx;
    else                  fixed = sum;

    inc = {1'b0, idx} + LW'(1);

    if (brev) nxt = (inc == len) ? '0 : inc[IW-1:0];
    else      nxt = fixed[IW-1:0];
  end
endmodule

// File: rtl/cag_channel.sv
module cag_channel
  import cag_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 10,
  parameter int LW = IW + 1,
  parameter int KW = $clog2(IW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_len,
  input  logic [LW-1:0] cfg_step,
  input  mode_e         cfg_mode,
  input  logic          adv,
  output logic [AW-1:0] ch_base,
  output logic [IW-1:0] ch_off
);
  logic [AW-1:0] base_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] step_q;
  mode_e         mode_q;
  logic [KW-1:0] k_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_nxt;
  logic [IW-1:0] idx_rev;
  logic [KW-1:0] k_d;

  assign k_d = KW'(cag_log2(32'(cfg_len)));

  cag_wrap #(.IW(IW), .LW(LW)) wrap_i (
    .idx  (idx_q),
    .len  (len_q),
    .step (step_q),
    .brev (mode_q == MODE_BREV),
    .nxt  (idx_nxt)
  );

  cag_bitrev #(.IW(IW), .KW(KW)) rev_i (
    .val (idx_q),
    .k   (k_q),
    .rev (idx_rev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= LW'(1);
      step_q <= '0;
      mode_q <= MODE_MOD;
      k_q    <= '0;
      idx_q  <= '0;
    end else if (cfg_we) begin
      base_q <= cfg_base;
      len_q  <= cfg_len;
      step_q <= cfg_step;
      mode_q <= cfg_mode;
      k_q    <= k_d;
      idx_q  <= '0;
    end else if (adv) begin
      idx_q  <= idx_nxt;
    end
  end

  assign ch_base = base_q;
  assign ch_off  = (mode_q == MODE_BREV) ? idx_rev : idx_q;

  // R3
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, idx_q} < len_q);

  // R6
  cfg_clears_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> idx_q == '0);

  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !adv) |=> ($stable(idx_q) && $stable(base_q)));
endmodule

// File: rtl/cag_out_stage.sv
module cag_out_stage #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] sel_addr,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_addr  <= sel_addr;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  // R2
  take_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import cag_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int IW  = 10,
  localparam int LW = IW + 1,
  localparam int KW = $clog2(IW + 1),
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_ch,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_len,
  input  logic [LW-1:0] cfg_step,
  input  logic          cfg_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_ch,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr
);
  logic [AW-1:0]  ch_base [NCH];
  logic [IW-1:0]  ch_off  [NCH];
  logic [NCH-1:0] adv_vec;
  logic           take;
  logic [AW-1:0]  sel_addr;

  assign req_ready = !addr_valid || addr_ready;
  assign take      = req_valid && req_ready;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic wr_here;
      assign wr_here    = cfg_we && (cfg_ch == CW'(c));
      assign adv_vec[c] = take && (req_ch == CW'(c)) && !wr_here;

      cag_channel #(.AW(AW), .IW(IW), .LW(LW), .KW(KW)) ch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (wr_here),
        .cfg_base (cfg_base),
        .cfg_len  (cfg_len),
        .cfg_step (cfg_step),
        .cfg_mode (mode_e'(cfg_mode)),
        .adv      (adv_vec[c]),
        .ch_base  (ch_base[c]),
        .ch_off   (ch_off[c])
      );
    end
  endgenerate

  assign sel_addr = ch_base[req_ch] + AW'(ch_off[req_ch]);

  cag_out_stage #(.AW(AW)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .sel_addr  (sel_addr),
    .out_ready (addr_ready),
    .out_valid (addr_valid),
    .out_addr  (addr)
  );

  // R7
  single_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adv_vec));
endmodule

// File: tb/circ_addr_gen_tb_top.sv
module circ_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [15:0] cfg_base = '0;
  logic [10:0] cfg_len = 11'd1;
  logic [10:0] cfg_step = '0;
  logic        cfg_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_ch = '0;
  logic        addr_valid;
  logic        addr_ready = 1'b1;
  logic [15:0] addr;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  int mb [4];
  int ml [4];
  int ms [4];
  int mm [4];
  int mi [4];
  bit exp_valid = 1'b0;
  int exp_addr = 0;

  always #10 clk = ~clk;

  circ_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_step(cfg_step),
    .cfg_mode(cfg_mode), .req_valid(req_valid), .req_ready(req_ready),
    .req_ch(req_ch), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr(addr)
  );

  function automatic int lg2(int v);
    int r = 0;
    while ((1 << (r + 1)) <= v) r++;
    return r;
  endfunction

  function automatic int model_off(int ch);
    int k, r;
    if (mm[ch] == 0) return mi[ch];
    k = lg2(ml[ch]);
    r = 0;
    for (int i = 0; i < k; i++)
      if ((mi[ch] >> i) & 1) r |= 1 << (k - 1 - i);
    return r;
  endfunction

  function automatic int model_next(int ch);
    int s;
    if (mm[ch] == 1) return (mi[ch] + 1) % ml[ch];
    s = mi[ch] + ms[ch];
    while (s < 0) s += ml[ch];
    while (s >= ml[ch]) s -= ml[ch];
    return s;
  endfunction

  task automatic check(bit ok, string what, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(bit cw, int cch, int cb, int cl, int cs, bit cm,
                     bit rv, int rch, bit ar);
    bit exp_ready, acc;
    @(negedge clk);
    check(addr_valid == exp_valid, "addr_valid", addr_valid, exp_valid);
    if (exp_valid) check(addr == 16'(exp_addr), "addr", addr, exp_addr & 16'hffff);
    cfg_we = cw; cfg_ch = 2'(cch); cfg_base = 16'(cb); cfg_len = 11'(cl);
    cfg_step = 11'(cs); cfg_mode = cm;
    req_valid = rv; req_ch = 2'(rch); addr_ready = ar;
    #1;
    exp_ready = !exp_valid || ar;
    check(req_ready == exp_ready, "req_ready", req_ready, exp_ready);
    acc = rv && exp_ready;
    if (acc) begin
      exp_addr = (mb[rch] + model_off(rch)) & 16'hffff;
      if (!(cw && cch == rch)) mi[rch] = model_next(rch);
      exp_valid = 1'b1;
    end else if (ar) exp_valid = 1'b0;
    if (cw) begin
      mb[cch] = cb; ml[cch] = cl; ms[cch] = cs; mm[cch] = cm; mi[cch] = 0;
    end
  endtask

  task automatic req(int ch, bit ar);
    cyc(0, 0, 0, 1, 0, 0, 1, ch, ar);
  endtask

  task automatic cfg(int ch, int b, int l, int s, bit m);
    cyc(1, ch, b, l, s, m, 0, 0, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired got 0 expected 1");
    finish_run();
  end

  initial begin
    int ch, l, s;
    bit m;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin
      mb[i] = 0; ml[i] = 1; ms[i] = 0; mm[i] = 0; mi[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state and an unconfigured channel
    tag = "R1";
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 1);
    req(0, 1); req(3, 1);
    // R10: length 1 keeps returning base
    tag = "R10";
    cfg(0, 16'h0abc, 1, 1, 0);
    repeat (3) req(0, 1);

    // R4: bit-reversed length 8, back to back (R8)
    tag = "R4";
    cfg(1, 16'h0100, 8, 3, 1);
    repeat (10) req(1, 1);
    tag = "R8";
    for (int i = 0; i < 8; i++) req(i % 4, 1);

    // R3: step equal to length, negative length, negative step
    tag = "R3";
    cfg(2, 16'h0200, 5, 5, 0);  repeat (3) req(2, 1);
    cfg(2, 16'h0200, 5, -5, 0); repeat (3) req(2, 1);
    cfg(2, 16'h0200, 5, -2, 0); repeat (7) req(2, 1);
    cfg(2, 16'h0200, 1024, 1023, 0); repeat (4) req(2, 1);

    // R5: address wraps through 16 bits
    tag = "R5";
    cfg(3, 16'hfffe, 6, 1, 0); repeat (7) req(3, 1);

    // R6: config and request to the same channel on one edge
    tag = "R6";
    req(2, 1);
    cyc(1, 2, 16'h0300, 4, 1, 0, 1, 2, 1);
    repeat (3) req(2, 1);
    cyc(1, 1, 16'h0400, 16, 0, 1, 1, 1, 1);
    repeat (4) req(1, 1);

    // R9: stall holds output and blocks advance
    tag = "R9";
    req(1, 0); req(1, 0); req(2, 0); req(3, 0);
    req(1, 1); req(1, 1);

    // R2 R7: random mix
    tag = "R2 R7";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(7) == 0) begin
        ch = int'($urandom_range(3));
        m  = 1'($urandom_range(1));
        if (m) l = 1 << $urandom_range(10);
        else   l = int'($urandom_range(1024, 1));
        s = int'($urandom_range(2 * l)) - l;
        if (s > 1023) s = 1023;
        cyc(1, ch, int'($urandom_range(16'hffff)), l, s, m,
            ($urandom_range(9) < 7), int'($urandom_range(3)), ($urandom_range(3) != 0));
      end else begin
        cyc(0, 0, 0, 1, 0, 0, ($urandom_range(9) < 7), int'($urandom_range(3)),
            ($urandom_range(3) != 0));
      end
    end
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 1);
    finish_run();
  end
endmodule